// File: doc/BRIEF.md
# Multi-Chain Averaging Time-Stamp Back-End

This block sits behind a bank of parallel tapped delay lines. All the lines look at the same hit. Each line delivers a fine-time code that has already been converted to binary, together with a one-cycle strobe, and it does so several times in a row for that one hit. The block collects the first `PASSES` codes from each of the `NUM_CHAINS` lines and adds them together. It captures the free-running coarse clock count in the cycle of the first strobe. It then emits one timestamp in which the coarse part is scaled to fine bins and the averaged fine part carries extra fractional bits. Averaging `NUM_CHAINS × PASSES` samples gives an effective bin well below one raw delay bin.

The number of samples per hit sets both the resolution gain and the dead time. More passes per line mean a longer collect window. More lines mean more adder logic for the same window. The collect window is bounded by a timeout, so a line that stops firing cannot lock up the block. Strobes that arrive from a line that has already delivered its quota are dropped and counted.

With the default parameters (8 lines, 4 passes, 400 bins per 5 ns clock) one sample of the output is 1/32 of a raw bin. A hit whose lines strobe every cycle completes in 4 cycles. A new hit is accepted in the very next cycle.

Top module: `tdc_multichain_avg`

## Requirements
- R1: While reset is held and directly after it, `stamp_vld`, `busy` and `tmo_err` are 0, `ovf_cnt` is 0 and `stamp_out` is 0.
- R2: When no window is open, a strobe on any line opens a collect window. `busy` is 1 from the cycle after the clock edge that samples that first strobe up to, but not including, the cycle in which the window closes.
- R3: The result equals `(coarse × BINS_PER_CLK) × 2^FRAC_W + S`, where S is the sum of the first `PASSES` accepted codes of every line and FRAC_W = log2(NUM_CHAINS × PASSES). With the defaults this is 5 fractional bits, so the integer part is in raw bins.
- R4: The coarse value used is the one present on `coarse_cnt` in the cycle of the first strobe. Later changes of `coarse_cnt` inside the window have no effect.
- R5: On the clock edge that samples the strobe completing the last line's quota, `stamp_out` is loaded, `stamp_vld` is 1 for exactly that one cycle and `busy` falls in the same cycle. `stamp_vld` stays 0 afterwards until another hit completes.
- R6: A strobe in the cycle directly after a completed result starts a new hit. When every line strobes each cycle, a hit therefore takes `PASSES` cycles, which is 20 ns with the defaults.
- R7: If the window has not completed within `TMO_CYC` cycles, counting the first-strobe cycle, the window closes. `tmo_err` is then 1 for one cycle, `busy` is 0, no result is emitted, and the next hit starts from empty tallies.
- R8: A strobe from a line that has already delivered `PASSES` codes in the open window does not change the result. Each cycle with at least one such strobe increments `ovf_cnt` by one.
- R9: `ovf_cnt` saturates at 2^OVF_W − 1 (255 with the defaults) and holds there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chain_fine | input | NUM_CHAINS×FINE_W | Binary fine code per line; line c occupies bits [c×FINE_W +: FINE_W] |
| chain_vld | input | NUM_CHAINS | One-cycle strobe per line qualifying its fine code |
| coarse_cnt | input | COARSE_W | Free-running coarse clock count |
| stamp_out | output | TS_W | Averaged timestamp with FRAC_W fractional bits |
| stamp_vld | output | 1 | One-cycle pulse when `stamp_out` is loaded |
| busy | output | 1 | Collect window open |
| tmo_err | output | 1 | One-cycle pulse when a window is closed by timeout |
| ovf_cnt | output | OVF_W | Saturating count of cycles carrying surplus strobes |

## Verification
The bench runs hits in which the lines start at different cycles and with different spacing between passes. A design that closed the window on the first full line, or that summed the codes of the wrong cycle, would emit a stamp too early or with a wrong value. The coarse input moves on every cycle of a hit, so a design that latched it at completion instead of at the first strobe would show an offset. Hits are also issued back to back with no idle cycle; a block that needed a recovery cycle would drop or merge them. Directed cases cover the following: a lone line that triggers the timeout, which must leave no stale tally for the next hit; surplus strobes carrying large codes, which must not leak into the sum; and enough surplus strobes to push the overflow counter into saturation, where a wrapping counter would fall back to small values.

// File: rtl/tdc_avg_pkg.sv
package tdc_avg_pkg;

   typedef enum logic [0:0] {
      ST_IDLE    = 1'b0,
      ST_COLLECT = 1'b1
   } win_state_t;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/tdc_lane_tally.sv
// Per-line pass counter: accepts the first PASSES strobes of a window,
// flags surplus strobes, and predicts completion for this cycle.
module tdc_lane_tally #(
   parameter int PASSES = 4,
   localparam int CNT_W = $clog2(PASSES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic vld,
   output logic accept,
   output logic excess,
   output logic full_next
);
   logic [CNT_W-1:0] cnt;

   assign accept    = vld && (cnt < CNT_W'(PASSES));
   assign excess    = vld && (cnt == CNT_W'(PASSES));
   assign full_next = (cnt + CNT_W'(accept)) == CNT_W'(PASSES);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         cnt <= '0;
      end else if (accept) begin
         cnt <= cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/tdc_fine_adder.sv
// Sums the fine codes of all lines whose strobe is accepted this cycle.
module tdc_fine_adder #(
   parameter int LANES  = 8,
   parameter int FINE_W = 9,
   parameter int SUM_W  = 14
) (
   input  logic [LANES*FINE_W-1:0] fine,
   input  logic [LANES-1:0]        take,
   output logic [SUM_W-1:0]        total
);
   always_comb begin
      total = '0;
      for (int i = 0; i < LANES; i++) begin
         if (take[i]) begin
            total = total + SUM_W'(fine[i*FINE_W +: FINE_W]);
         end
      end
   end
endmodule

// File: rtl/tdc_stamp_merge.sv
// Scales the coarse count to fine bins and adds the averaged fine part
// with FRAC_W fractional bits.
module tdc_stamp_merge
   import tdc_avg_pkg::*;
#(
   parameter int COARSE_W     = 16,
   parameter int BINS_PER_CLK = 400,
   parameter int SAMPLES      = 32,
   parameter int SUM_W        = 14,
   parameter int FRAC_W       = 5,
   parameter int TS_W         = 31,
   localparam int WIDE_W      = SUM_W + FRAC_W
) (
   input  logic [COARSE_W-1:0] coarse,
   input  logic [SUM_W-1:0]    sum,
   output logic [TS_W-1:0]     stamp
);
   logic [WIDE_W-1:0] frac_part;
   logic [TS_W-1:0]   base;

   generate
      if (is_pow2(SAMPLES)) begin : g_shift
         // dividing by 2^FRAC_W and keeping FRAC_W fraction bits is the sum itself
         assign frac_part = WIDE_W'(sum);
      end else begin : g_divide
         logic [WIDE_W-1:0] scaled;
         assign scaled    = {sum, FRAC_W'(0)};
         assign frac_part = scaled / WIDE_W'(SAMPLES);
      end
   endgenerate

   assign base  = TS_W'(coarse) * TS_W'(BINS_PER_CLK);
   assign stamp = (base << FRAC_W) + TS_W'(frac_part);
endmodule

// File: rtl/tdc_multichain_avg.sv
module tdc_multichain_avg
   import tdc_avg_pkg::*;
#(
   parameter int NUM_CHAINS   = 8,
   parameter int PASSES       = 4,
   parameter int FINE_W       = 9,
   parameter int COARSE_W     = 16,
   parameter int BINS_PER_CLK = 400,
   parameter int TMO_CYC      = 16,
   parameter int OVF_W        = 8,
   localparam int SAMPLES     = NUM_CHAINS * PASSES,
   localparam int FRAC_W      = $clog2(SAMPLES),
   localparam int SUM_W       = FINE_W + FRAC_W,
   localparam int BIN_W       = $clog2(BINS_PER_CLK),
   localparam int TS_W        = COARSE_W + BIN_W + FRAC_W + 1,
   localparam int TMO_W       = $clog2(TMO_CYC + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_CHAINS*FINE_W-1:0] chain_fine,
   input  logic [NUM_CHAINS-1:0]        chain_vld,
   input  logic [COARSE_W-1:0]          coarse_cnt,
   output logic [TS_W-1:0]              stamp_out,
   output logic                         stamp_vld,
   output logic                         busy,
   output logic                         tmo_err,
   output logic [OVF_W-1:0]             ovf_cnt
);
   // elaboration-time parameter checks
   if (NUM_CHAINS < 1) begin : g_bad_chains
      $error("NUM_CHAINS must be at least 1");
   end
   if (PASSES < 1) begin : g_bad_passes
      $error("PASSES must be at least 1");
   end
   if (SAMPLES < 2) begin : g_bad_samples
      $error("NUM_CHAINS*PASSES must be at least 2");
   end
   if (FINE_W > BIN_W) begin : g_bad_fine
      $error("fine code wider than one coarse period");
   end
   if (TMO_CYC <= PASSES) begin : g_bad_tmo
      $error("TMO_CYC must exceed PASSES");
   end
   if (OVF_W < 1) begin : g_bad_ovf
      $error("OVF_W must be at least 1");
   end

   win_state_t               st;
   logic [TMO_W-1:0]         tmo_cnt;
   logic [COARSE_W-1:0]      coarse_q;
   logic [SUM_W-1:0]         sum_q;
   logic [NUM_CHAINS-1:0]    lane_accept;
   logic [NUM_CHAINS-1:0]    lane_excess;
   logic [NUM_CHAINS-1:0]    lane_full;
   logic [SUM_W-1:0]         step_sum;
   logic [SUM_W-1:0]         sum_next;
   logic [COARSE_W-1:0]      coarse_sel;
   logic [TS_W-1:0]          stamp_d;
   logic                     start, active, all_full, done, tmo_hit, win_close;

   generate
      for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_lane
         tdc_lane_tally #(.PASSES(PASSES)) u_tally (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (win_close),
            .vld       (chain_vld[c]),
            .accept    (lane_accept[c]),
            .excess    (lane_excess[c]),
            .full_next (lane_full[c])
         );
      end
   endgenerate

   tdc_fine_adder #(.LANES(NUM_CHAINS), .FINE_W(FINE_W), .SUM_W(SUM_W)) u_adder (
      .fine  (chain_fine),
      .take  (lane_accept),
      .total (step_sum)
   );

   assign start     = (st == ST_IDLE) && (|chain_vld);
   assign active    = (st == ST_COLLECT) || start;
   assign all_full  = &lane_full;
   assign done      = active && all_full;
   assign tmo_hit   = (st == ST_COLLECT) && !all_full && (tmo_cnt == TMO_W'(TMO_CYC - 1));
   assign win_close = done || tmo_hit;
   assign sum_next  = ((st == ST_IDLE) ? SUM_W'(0) : sum_q) + step_sum;
   assign coarse_sel = start ? coarse_cnt : coarse_q;

   tdc_stamp_merge #(
      .COARSE_W     (COARSE_W),
      .BINS_PER_CLK (BINS_PER_CLK),
      .SAMPLES      (SAMPLES),
      .SUM_W        (SUM_W),
      .FRAC_W       (FRAC_W),
      .TS_W         (TS_W)
   ) u_merge (
      .coarse (coarse_sel),
      .sum    (sum_next),
      .stamp  (stamp_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         tmo_cnt   <= '0;
         coarse_q  <= '0;
         sum_q     <= '0;
         stamp_out <= '0;
         stamp_vld <= 1'b0;
         tmo_err   <= 1'b0;
         ovf_cnt   <= '0;
      end else begin
         stamp_vld <= done;
         tmo_err   <= tmo_hit;
         if (done) begin
            stamp_out <= stamp_d;
         end
         if (start) begin
            coarse_q <= coarse_cnt;
         end
         if (win_close) begin
            st      <= ST_IDLE;
            sum_q   <= '0;
            tmo_cnt <= '0;
         end else if (active) begin
            st      <= ST_COLLECT;
            sum_q   <= sum_next;
            tmo_cnt <= tmo_cnt + TMO_W'(1);
         end
         if ((|lane_excess) && (ovf_cnt != {OVF_W{1'b1}})) begin
            ovf_cnt <= ovf_cnt + OVF_W'(1);
         end
      end
   end

   assign busy = (st == ST_COLLECT);
endmodule

// File: rtl/tdc_avg_checker.sv
module tdc_avg_checker #(
   parameter int NUM_CHAINS = 8,
   parameter int PASSES     = 4,
   parameter int TMO_CYC    = 16,
   parameter int OVF_W      = 8,
   localparam int RUN_W     = $clog2(TMO_CYC + 2)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NUM_CHAINS-1:0] chain_vld,
   input logic                  stamp_vld,
   input logic                  busy,
   input logic                  tmo_err,
   input logic [OVF_W-1:0]      ovf_cnt
);
   logic [RUN_W-1:0] busy_run;

   always_ff @(posedge clk) begin
      if (!rst_n || !busy) begin
         busy_run <= '0;
      end else if (busy_run != {RUN_W{1'b1}}) begin
         busy_run <= busy_run + RUN_W'(1);
      end
   end

   p_busy_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(|chain_vld));

   p_busy_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (stamp_vld || tmo_err));

   p_vld_not_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stamp_vld |-> !busy);

   p_vld_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (PASSES > 1) && stamp_vld |=> !stamp_vld);

   p_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(stamp_vld && tmo_err));

   p_window_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run < RUN_W'(TMO_CYC));

   p_ovf_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (ovf_cnt == $past(ovf_cnt)) || (ovf_cnt == $past(ovf_cnt) + OVF_W'(1)));

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_cnt == {OVF_W{1'b1}}) |=> (ovf_cnt == {OVF_W{1'b1}}));
endmodule

bind tdc_multichain_avg tdc_avg_checker #(
   .NUM_CHAINS (NUM_CHAINS),
   .PASSES     (PASSES),
   .TMO_CYC    (TMO_CYC),
   .OVF_W      (OVF_W)
) u_avg_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .chain_vld (chain_vld),
   .stamp_vld (stamp_vld),
   .busy      (busy),
   .tmo_err   (tmo_err),
   .ovf_cnt   (ovf_cnt)
);

// File: tb/test_tdc_multichain_avg.sv
`timescale 1ns/1ps
module test_tdc_multichain_avg;
   localparam int M    = 8;
   localparam int N    = 4;
   localparam int FW   = 9;
   localparam int CW   = 16;
   localparam int BINS = 400;
   localparam int TMO  = 16;
   localparam int OW   = 8;
   localparam int FRAC = 5;
   localparam int TSW  = CW + 9 + FRAC + 1;

   localparam int NV = 6;
   localparam int V_COARSE [NV] = '{100, 0, 65535, 1234, 777, 42};
   localparam int V_SEED   [NV] = '{5, 399, 250, 0, 123, 300};
   localparam int V_SKEW   [NV] = '{0, 0, 2, 0, 2, 1};
   localparam int V_GAP    [NV] = '{1, 1, 1, 2, 2, 3};

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [M*FW-1:0] chain_fine = '0;
   logic [M-1:0]    chain_vld = '0;
   logic [CW-1:0]   coarse_cnt = '0;
   logic [TSW-1:0]  stamp_out;
   logic            stamp_vld, busy, tmo_err;
   logic [OW-1:0]   ovf_cnt;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   tdc_multichain_avg #(
      .NUM_CHAINS(M), .PASSES(N), .FINE_W(FW), .COARSE_W(CW),
      .BINS_PER_CLK(BINS), .TMO_CYC(TMO), .OVF_W(OW)
   ) i_tdc_multichain_avg (
      .clk(clk), .rst_n(rst_n), .chain_fine(chain_fine), .chain_vld(chain_vld),
      .coarse_cnt(coarse_cnt), .stamp_out(stamp_out), .stamp_vld(stamp_vld),
      .busy(busy), .tmo_err(tmo_err), .ovf_cnt(ovf_cnt)
   );

   task automatic eq(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int fine_of(input int seed, input int c, input int p);
      return (seed + 37 * c + 11 * p) % BINS;
   endfunction

   // one hit: line c starts at cycle c%(skew+1), passes spaced by gap cycles
   task automatic run_hit(input int coarse, input int seed, input int skew,
                          input int gap, input string tag);
      int last = skew + (N - 1) * gap;
      longint sum = 0;
      longint exp;
      for (int c = 0; c < M; c++)
         for (int p = 0; p < N; p++)
            sum += fine_of(seed, c, p);
      exp = ((longint'(coarse) * BINS) <<< FRAC) + sum;
      for (int k = 0; k <= last; k++) begin
         chain_vld = '0;
         for (int c = 0; c < M; c++) begin
            int st = c % (skew + 1);
            if (k >= st && ((k - st) % gap) == 0 && ((k - st) / gap) < N) begin
               chain_vld[c] = 1'b1;
               chain_fine[c*FW +: FW] = FW'(fine_of(seed, c, (k - st) / gap));
            end
         end
         coarse_cnt = CW'(coarse + k);
         @(negedge clk);
         if (k < last) begin
            eq({tag, " R2 busy in window"}, longint'(busy), 1);
            eq({tag, " R5 no early valid"}, longint'(stamp_vld), 0);
         end else begin
            eq({tag, " R5 valid on completion"}, longint'(stamp_vld), 1);
            eq({tag, " R5 busy falls"}, longint'(busy), 0);
            eq({tag, " R3 R4 stamp"}, longint'(stamp_out), exp);
         end
      end
      chain_vld = '0;
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         chain_vld = '0;
         coarse_cnt = coarse_cnt + CW'(3);
         @(negedge clk);
         eq({tag, " R5 no repeat valid"}, longint'(stamp_vld), 0);
         eq({tag, " R2 idle not busy"}, longint'(busy), 0);
      end
   endtask

   // chain0 strobes every cycle, others never: closes by timeout
   task automatic lone_window(input int cycles);
      for (int k = 0; k < cycles; k++) begin
         chain_vld = '0;
         chain_vld[0] = 1'b1;
         chain_fine[0 +: FW] = FW'(k);
         @(negedge clk);
      end
      chain_vld = '0;
   endtask

   task automatic print_summary;
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      print_summary();
   end

   initial begin
      int ovf0;
      longint s_ovf;
      repeat (3) @(negedge clk);
      // R1: reset state, held and after release
      eq("R1 valid in reset", longint'(stamp_vld), 0);
      eq("R1 busy in reset", longint'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);
      eq("R1 valid", longint'(stamp_vld), 0);
      eq("R1 busy", longint'(busy), 0);
      eq("R1 tmo", longint'(tmo_err), 0);
      eq("R1 ovf", longint'(ovf_cnt), 0);
      eq("R1 stamp", longint'(stamp_out), 0);

      // table walk: odd entries run back to back with the next one
      for (int i = 0; i < NV; i++) begin
         run_hit(V_COARSE[i], V_SEED[i], V_SKEW[i], V_GAP[i], $sformatf("vec%0d", i));
         if ((i % 2) == 0) idle(1, $sformatf("vec%0d", i));
      end
      idle(2, "post table");

      // R6: two hits with no gap, every line strobing each cycle
      run_hit(500, 17, 0, 1, "R6 first");
      run_hit(501, 211, 0, 1, "R6 second");
      idle(1, "R6");

      // R7: lone strobe, window must time out
      chain_vld = '0;
      chain_vld[2] = 1'b1;
      chain_fine[2*FW +: FW] = FW'(99);
      coarse_cnt = 16'd9;
      for (int k = 0; k < TMO; k++) begin
         @(negedge clk);
         chain_vld = '0;
         eq("R7 no valid on timeout", longint'(stamp_vld), 0);
         eq("R7 busy", longint'(busy), (k < TMO - 1) ? 1 : 0);
         eq("R7 tmo_err", longint'(tmo_err), (k == TMO - 1) ? 1 : 0);
      end
      @(negedge clk);
      eq("R7 tmo_err single", longint'(tmo_err), 0);
      run_hit(321, 77, 1, 1, "R7 clean after timeout");

      // R8: chain0 fires 6 times (2 surplus, large codes), others from cycle 2
      ovf0 = ovf_cnt;
      s_ovf = 0;
      for (int k = 0; k < 6; k++) begin
         chain_vld = '0;
         chain_vld[0] = 1'b1;
         chain_fine[0 +: FW] = (k < N) ? FW'(fine_of(60, 0, k)) : FW'(399);
         if (k < N) s_ovf += fine_of(60, 0, k);
         if (k >= 2) begin
            for (int c = 1; c < M; c++) begin
               chain_vld[c] = 1'b1;
               chain_fine[c*FW +: FW] = FW'(fine_of(60, c, k - 2));
               s_ovf += fine_of(60, c, k - 2);
            end
         end
         coarse_cnt = CW'(2000 + k);
         @(negedge clk);
      end
      chain_vld = '0;
      eq("R8 valid despite surplus", longint'(stamp_vld), 1);
      eq("R8 surplus ignored in stamp", longint'(stamp_out),
         ((longint'(2000) * BINS) <<< FRAC) + s_ovf);
      eq("R8 ovf increments", longint'(ovf_cnt), ovf0 + 2);

      // R9: drive surplus strobes until the counter saturates
      for (int w = 0; w < 22; w++) lone_window(TMO);
      @(negedge clk);
      eq("R9 ovf saturated", longint'(ovf_cnt), 255);
      lone_window(TMO);
      @(negedge clk);
      eq("R9 ovf holds", longint'(ovf_cnt), 255);
      run_hit(8, 3, 0, 1, "R9 hit after saturation");

      print_summary();
   end
endmodule